// File: doc/BRIEF.md
# Bus Breakpoint Stall Controller

This block is a debug monitor on a microprocessor backplane. It looks at every bus cycle through sampled copies of the status-valid strobe, the sync line, the data-in line and the memory-read status. It operates on a fast local clock. A bus cycle is marked by the rising edge of the strobe while sync is high. On that edge the block latches the cycle address into a display register. It then compares the latched address with a programmable break address. If they match, it holds the processor by pulling its ready output low. The stall therefore lands on the matching cycle and not on the one after it.

An optional qualifier limits breaks to memory-read cycles. Without it, a write to the break address also breaks. A drive enable decides whether the block may pull ready low at all. Two commands control a held processor. A single-step request lets one cycle go and stops at the next marked cycle. A run request resumes and ignores further cycles at the same address until the bus has shown a different address.

A data display follows the data bus while data-in is high and keeps the last value seen otherwise.

The decision takes one local clock after the capture edge when `MATCH_REG` is 0, and two when it is 1. In the list below, "the edge after capture" means the edge that makes this decision.

Top module: `bus_break_ctl`

## Requirements
- R1: A cycle is captured only on a clock where the sampled strobe is high, it was low on the previous clock, and sync is high. On that edge `disp_addr_o` takes `bus_addr_i`. A strobe that was already high when sync rose captures nothing.
- R2: After a captured cycle whose address equals `brk_addr_i`, `rdy_o` goes low from the edge after capture when `MATCH_REG` is 0. It stays low until step, run or disable.
- R3: With `memr_only_i` = 1, a captured cycle breaks only if `memr_i` was 1 on the capture clock. With `memr_only_i` = 0, a write cycle (`memr_i` = 0) at the break address also breaks.
- R4: While `brk_drive_en_i` is 0, `rdy_o` is 1 and `held_o` is 0 in the same clock. Held and step states are dropped and step requests are ignored.
- R5: A `step_req_i` pulse while held raises `rdy_o` after the next edge. The next captured cycle then stalls, whatever its address.
- R6: A `run_req_i` pulse frees the processor and records the captured address. Later cycles at that address do not break. Once a cycle with a different address has been decided, the break address breaks again.
- R7: When run and step are requested on the same clock, run wins, and the next cycle at another address does not stall.
- R8: `disp_data_o` equals `bus_data_i` while `dbin_i` is 1. While `dbin_i` is 0, it shows the value sampled on the last clock where `dbin_i` was 1.
- R9: `held_o` is always the inverse of `rdy_o`. It is high exactly while a break or a step holds the processor.
- R10: After reset, `rdy_o` = 1, `held_o` = 0, `disp_addr_o` = 0, and `disp_data_o` = 0 while `dbin_i` is 0.
- R11: With a source that gives two strobe pulses per cycle, the first pulse (sync low) neither captures nor breaks. The second pulse (sync high) is the one that marks the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Sampled bus address |
| bus_data_i | input | DATA_W | Sampled data bus |
| stb_i | input | 1 | Sampled status-valid strobe, active high |
| sync_i | input | 1 | Sampled cycle sync, active high |
| dbin_i | input | 1 | Sampled data-in strobe, active high |
| memr_i | input | 1 | Sampled memory-read status |
| brk_addr_i | input | ADDR_W | Break address |
| brk_drive_en_i | input | 1 | Allows the block to pull ready low |
| memr_only_i | input | 1 | Limits breaks to memory reads |
| step_req_i | input | 1 | One-clock single-step request |
| run_req_i | input | 1 | One-clock resume request |
| rdy_o | output | 1 | Ready to the processor, low holds it |
| held_o | output | 1 | High while the processor is held |
| disp_addr_o | output | ADDR_W | Captured cycle address for display |
| disp_data_o | output | DATA_W | Data display |

## Verification
Plain sync-marked cycles at both the break address and other addresses show that the stall falls on the matching cycle itself. Three strobe shapes at the break address separate leading-edge gating from level gating: a lone strobe with sync low, a strobe already high when sync rises, and a two-pulse cycle. Write and read cycles, run once with the qualifier on and once with it off, show the qualifier's effect. The run path is tested with the same address repeated, then a different address, then the break address again. This separates the skip logic from plain matching. Step and run requests are also issued on the same clock and while the drive enable is off, to expose their priority.

// File: rtl/bbk_pkg.sv
package bbk_pkg;

   typedef enum logic [1:0] {
      HS_FREE = 2'd0,
      HS_HELD = 2'd1,
      HS_STEP = 2'd2
   } hold_state_e;

endpackage

// File: rtl/bbk_edge.sv
module bbk_edge #(
   parameter int N = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl_i,
   output logic [N-1:0] rise_o
);

   if (N < 1) begin : g_bad_n
      $error("bbk_edge: N must be at least 1");
   end

   logic [N-1:0] lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl_i;
   end

   for (genvar g = 0; g < N; g++) begin : g_bit
      assign rise_o[g] = lvl_i[g] & ~lvl_q[g];
   end

endmodule

// File: rtl/bbk_capture.sv
module bbk_capture #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              memr_i,
   output logic [ADDR_W-1:0] cap_addr_o,
   output logic              cap_memr_o,
   output logic              cap_v_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_addr_o <= '0;
         cap_memr_o <= 1'b0;
         cap_v_o    <= 1'b0;
      end else begin
         cap_v_o <= ev_i;
         if (ev_i) begin
            cap_addr_o <= addr_i;
            cap_memr_o <= memr_i;
         end
      end
   end

   // R1: without a marked cycle the captured address must not move
   assert_addr_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_i |=> $stable(cap_addr_o));

endmodule

// File: rtl/bbk_match.sv
module bbk_match #(
   parameter int ADDR_W    = 16,
   parameter int MATCH_REG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_v_i,
   input  logic [ADDR_W-1:0] cap_addr_i,
   input  logic              cap_memr_i,
   input  logic [ADDR_W-1:0] brk_addr_i,
   input  logic              memr_only_i,
   output logic              hit_v_o,
   output logic              hit_brk_o,
   output logic [ADDR_W-1:0] hit_addr_o
);

   if (MATCH_REG != 0 && MATCH_REG != 1) begin : g_bad_reg
      $error("bbk_match: MATCH_REG must be 0 or 1");
   end

   logic addr_eq;
   logic type_ok;
   logic brk_now;

   assign addr_eq = (cap_addr_i == brk_addr_i);
   assign type_ok = !memr_only_i || cap_memr_i;
   assign brk_now = addr_eq && type_ok;

   if (MATCH_REG == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hit_v_o    <= 1'b0;
            hit_brk_o  <= 1'b0;
            hit_addr_o <= '0;
         end else begin
            hit_v_o    <= cap_v_i;
            hit_brk_o  <= brk_now;
            hit_addr_o <= cap_addr_i;
         end
      end
   end else begin : g_comb
      assign hit_v_o    = cap_v_i;
      assign hit_brk_o  = brk_now;
      assign hit_addr_o = cap_addr_i;
   end

endmodule

// File: rtl/bbk_stall.sv
module bbk_stall
   import bbk_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              run_i,
   input  logic              step_i,
   input  logic              hit_v_i,
   input  logic              hit_brk_i,
   input  logic [ADDR_W-1:0] hit_addr_i,
   input  logic [ADDR_W-1:0] cap_addr_i,
   output logic              held_o
);

   hold_state_e       state_q, state_d;
   logic              skip_q, skip_d;
   logic [ADDR_W-1:0] skip_addr_q, skip_addr_d;
   logic              suppress;

   assign suppress = skip_q && (hit_addr_i == skip_addr_q);

   always_comb begin
      state_d = state_q;
      if (!en_i)
         state_d = HS_FREE;
      else if (run_i)
         state_d = HS_FREE;
      else if (step_i)
         state_d = HS_STEP;
      else if (hit_v_i && (state_q == HS_STEP ||
               (state_q == HS_FREE && hit_brk_i && !suppress)))
         state_d = HS_HELD;
   end

   always_comb begin
      skip_d      = skip_q;
      skip_addr_d = skip_addr_q;
      if (run_i) begin
         skip_d      = 1'b1;
         skip_addr_d = cap_addr_i;
      end else if (hit_v_i && hit_addr_i != skip_addr_q) begin
         skip_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= HS_FREE;
         skip_q      <= 1'b0;
         skip_addr_q <= '0;
      end else begin
         state_q     <= state_d;
         skip_q      <= skip_d;
         skip_addr_q <= skip_addr_d;
      end
   end

   assign held_o = (state_q == HS_HELD) && en_i;

   assert_off_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !held_o);

   assert_step_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == HS_HELD && en_i && step_i && !run_i) |=> (state_q == HS_STEP));

   assert_hit_stalls_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !run_i && !step_i && state_q == HS_FREE && hit_v_i && hit_brk_i &&
       !(skip_q && hit_addr_i == skip_addr_q)) |=> (state_q == HS_HELD));

   assert_repeat_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !run_i && !step_i && state_q == HS_FREE && hit_v_i && skip_q &&
       hit_addr_i == skip_addr_q) |=> (state_q == HS_FREE));

   assert_run_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && step_i) |=> (state_q == HS_FREE));

endmodule

// File: rtl/bbk_display.sv
module bbk_display #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbin_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] disp_o
);

   logic [DATA_W-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hold_q <= '0;
      else if (dbin_i) hold_q <= data_i;
   end

   assign disp_o = dbin_i ? data_i : hold_q;

   assert_display_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dbin_i) |-> (disp_o == $past(data_i)));

endmodule

// File: rtl/bus_break_ctl.sv
module bus_break_ctl #(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int MATCH_REG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_data_i,
   input  logic              stb_i,
   input  logic              sync_i,
   input  logic              dbin_i,
   input  logic              memr_i,
   input  logic [ADDR_W-1:0] brk_addr_i,
   input  logic              brk_drive_en_i,
   input  logic              memr_only_i,
   input  logic              step_req_i,
   input  logic              run_req_i,
   output logic              rdy_o,
   output logic              held_o,
   output logic [ADDR_W-1:0] disp_addr_o,
   output logic [DATA_W-1:0] disp_data_o
);

   if (ADDR_W < 4 || ADDR_W > 64) begin : g_bad_aw
      $error("bus_break_ctl: ADDR_W out of range");
   end
   if (DATA_W < 1 || DATA_W > 64) begin : g_bad_dw
      $error("bus_break_ctl: DATA_W out of range");
   end

   logic [0:0]        stb_rise;
   logic              cyc_ev;
   logic              cap_v, cap_memr;
   logic [ADDR_W-1:0] cap_addr;
   logic              hit_v, hit_brk;
   logic [ADDR_W-1:0] hit_addr;
   logic              held;

   bbk_edge #(.N(1)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (stb_i),
      .rise_o (stb_rise)
   );

   assign cyc_ev = stb_rise[0] && sync_i;

   bbk_capture #(.ADDR_W(ADDR_W)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_i       (cyc_ev),
      .addr_i     (bus_addr_i),
      .memr_i     (memr_i),
      .cap_addr_o (cap_addr),
      .cap_memr_o (cap_memr),
      .cap_v_o    (cap_v)
   );

   bbk_match #(.ADDR_W(ADDR_W), .MATCH_REG(MATCH_REG)) u_match (
      .clk         (clk),
      .rst_n       (rst_n),
      .cap_v_i     (cap_v),
      .cap_addr_i  (cap_addr),
      .cap_memr_i  (cap_memr),
      .brk_addr_i  (brk_addr_i),
      .memr_only_i (memr_only_i),
      .hit_v_o     (hit_v),
      .hit_brk_o   (hit_brk),
      .hit_addr_o  (hit_addr)
   );

   bbk_stall #(.ADDR_W(ADDR_W)) u_stall (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (brk_drive_en_i),
      .run_i      (run_req_i),
      .step_i     (step_req_i),
      .hit_v_i    (hit_v),
      .hit_brk_i  (hit_brk),
      .hit_addr_i (hit_addr),
      .cap_addr_i (cap_addr),
      .held_o     (held)
   );

   bbk_display #(.DATA_W(DATA_W)) u_disp (
      .clk    (clk),
      .rst_n  (rst_n),
      .dbin_i (dbin_i),
      .data_i (bus_data_i),
      .disp_o (disp_data_o)
   );

   assign held_o      = held;
   assign rdy_o       = ~held;
   assign disp_addr_o = cap_addr;

   // R1: a lone strobe (sync low) never marks a cycle
   assert_lone_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_i) |=> !cap_v);

endmodule

// File: tb/bus_break_ctl_test.sv
`timescale 1ns/1ps
module bus_break_ctl_test;

   localparam int AW  = 16;
   localparam int DW  = 8;
   localparam int LAT = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] data = '0;
   logic          stb = 1'b0, sync = 1'b0, dbin = 1'b0, memr = 1'b0;
   logic [AW-1:0] brk = '0;
   logic          en = 1'b0, memr_only = 1'b0, step = 1'b0, run = 1'b0;
   logic          rdy, held;
   logic [AW-1:0] daddr;
   logic [DW-1:0] ddata;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   bus_break_ctl #(.ADDR_W(AW), .DATA_W(DW), .MATCH_REG(0)) uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .bus_addr_i     (addr),
      .bus_data_i     (data),
      .stb_i          (stb),
      .sync_i         (sync),
      .dbin_i         (dbin),
      .memr_i         (memr),
      .brk_addr_i     (brk),
      .brk_drive_en_i (en),
      .memr_only_i    (memr_only),
      .step_req_i     (step),
      .run_req_i      (run),
      .rdy_o          (rdy),
      .held_o         (held),
      .disp_addr_o    (daddr),
      .disp_data_o    (ddata)
   );

   // ---------------- reference model ----------------
   typedef struct {
      logic [AW-1:0] a;
      logic          m;
      int            due;
   } ev_t;

   ev_t           evq[$];
   int            m_state = 0;      // 0 free, 1 held, 2 stepping
   bit            m_skip = 0;
   logic [AW-1:0] m_skip_addr = '0;
   logic [AW-1:0] m_cap = '0;
   logic [DW-1:0] m_hold = '0;
   logic          m_stb_q = 1'b0;
   int            cyc = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_skip = 0; m_skip_addr = '0; m_cap = '0;
         m_hold = '0; m_stb_q = 1'b0; evq.delete(); cyc = 0;
      end else begin
         ev_t e;
         bit  hv, brk_hit, sup;
         int  ns;
         e  = '{a: '0, m: 1'b0, due: 0};
         hv = 0;
         cyc++;
         if (evq.size() > 0 && evq[0].due == cyc) begin
            e  = evq.pop_front();
            hv = 1;
         end
         brk_hit = hv && (e.a == brk) && (!memr_only || e.m);
         sup     = m_skip && (e.a == m_skip_addr);
         ns = m_state;
         if (!en)       ns = 0;
         else if (run)  ns = 0;
         else if (step) ns = 2;
         else if (hv && (m_state == 2 || (m_state == 0 && brk_hit && !sup))) ns = 1;
         if (run) begin
            m_skip = 1; m_skip_addr = m_cap;
         end else if (hv && e.a != m_skip_addr) begin
            m_skip = 0;
         end
         m_state = ns;
         if (stb && !m_stb_q && sync) begin
            m_cap = addr;
            evq.push_back('{a: addr, m: memr, due: cyc + LAT});
         end
         m_stb_q = stb;
         if (dbin) m_hold = data;
      end
   end

   // ---------------- checking ----------------
   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      logic exp_held;
      exp_held = (m_state == 1) && en;
      chk("R2 rdy_o vs model",       rdy,   !exp_held);
      chk("R9 held_o vs model",      held,  exp_held);
      chk("R1 disp_addr_o vs model", daddr, m_cap);
      chk("R8 disp_data_o vs model", ddata, dbin ? data : m_hold);
   endtask

   task automatic cyc1();
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc1();
   endtask

   task automatic bus_cycle(logic [AW-1:0] a, logic mr, bit two_pulse);
      addr = a; memr = mr;
      if (two_pulse) begin
         stb = 1'b1; cyc1();
         stb = 1'b0; cyc1();
      end
      sync = 1'b1; cyc1();
      stb  = 1'b1; cyc1();
      stb  = 1'b0; cyc1();
      sync = 1'b0; cyc1();
      idle(2);
   endtask

   task automatic pulse_step();
      step = 1'b1; cyc1(); step = 1'b0; cyc1();
   endtask

   task automatic pulse_run();
      run = 1'b1; cyc1(); run = 1'b0; cyc1();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      idle(3);
      // R10 reset state
      chk("R10 rdy_o after reset",       rdy,   1);
      chk("R10 held_o after reset",      held,  0);
      chk("R10 disp_addr_o after reset", daddr, 0);
      chk("R10 disp_data_o after reset", ddata, 0);
      rst_n = 1'b1;
      brk = 16'h1234; en = 1'b1; memr_only = 1'b0;
      idle(2);

      // R1 other address, no break
      bus_cycle(16'h1000, 1'b1, 0);
      chk("R1 captured address", daddr, 16'h1000);
      chk("R2 no break on other address", rdy, 1);

      // R11 lone strobe at break address, sync low
      addr = 16'h1234; stb = 1'b1; cyc1(); stb = 1'b0; idle(3);
      chk("R11 lone strobe leaves address", daddr, 16'h1000);
      chk("R11 lone strobe no break", rdy, 1);

      // R1 strobe already high when sync rises
      stb = 1'b1; cyc1(); sync = 1'b1; cyc1(); stb = 1'b0; cyc1(); sync = 1'b0; idle(3);
      chk("R1 level strobe no capture", daddr, 16'h1000);
      chk("R1 level strobe no break", rdy, 1);

      // R3 write at break address with qualifier off -> break
      bus_cycle(16'h1234, 1'b0, 0);
      chk("R3 write breaks when unqualified", rdy, 0);
      chk("R9 held while stalled", held, 1);

      // R5 single step
      pulse_step();
      chk("R5 step releases", rdy, 1);
      bus_cycle(16'h2000, 1'b1, 0);
      chk("R5 next cycle stalls", rdy, 0);
      chk("R5 stalled address", daddr, 16'h2000);

      // R6 run / skip
      pulse_run();
      chk("R6 run releases", rdy, 1);
      bus_cycle(16'h1234, 1'b1, 0);
      chk("R6 break address stalls again", rdy, 0);
      pulse_run();
      bus_cycle(16'h1234, 1'b1, 0);
      chk("R6 same address skipped after run", rdy, 1);
      bus_cycle(16'h1235, 1'b1, 0);
      chk("R6 other address no break", rdy, 1);
      bus_cycle(16'h1234, 1'b1, 0);
      chk("R6 re-break after other address", rdy, 0);

      // R3 qualifier on
      memr_only = 1'b1;
      pulse_run();
      bus_cycle(16'h3000, 1'b1, 0);
      bus_cycle(16'h1234, 1'b0, 0);
      chk("R3 qualified write ignored", rdy, 1);
      bus_cycle(16'h1234, 1'b1, 0);
      chk("R3 qualified read breaks", rdy, 0);

      // R11 two-pulse source
      pulse_run();
      bus_cycle(16'h3000, 1'b1, 0);
      bus_cycle(16'h1234, 1'b1, 1);
      chk("R11 second pulse breaks", rdy, 0);
      chk("R11 address from second pulse", daddr, 16'h1234);

      // R4 drive enable
      en = 1'b0; cyc1();
      chk("R4 disable releases at once", rdy, 1);
      chk("R4 disable clears held", held, 0);
      pulse_step();
      bus_cycle(16'h5000, 1'b1, 0);
      bus_cycle(16'h1234, 1'b1, 0);
      chk("R4 no stall while disabled", rdy, 1);
      en = 1'b1; idle(2);
      chk("R4 re-enable stays free", rdy, 1);

      // R7 run and step together
      pulse_step();
      bus_cycle(16'h6000, 1'b1, 0);
      chk("R7 setup held by step", rdy, 0);
      run = 1'b1; step = 1'b1; cyc1(); run = 1'b0; step = 1'b0; cyc1();
      bus_cycle(16'h4000, 1'b1, 0);
      chk("R7 run wins over step", rdy, 1);

      // R8 data display
      data = 8'hA5; dbin = 1'b1; cyc1();
      chk("R8 transparent", ddata, 8'hA5);
      data = 8'h3C; cyc1();
      chk("R8 follows data", ddata, 8'h3C);
      dbin = 1'b0; data = 8'hFF; cyc1();
      chk("R8 holds when data-in low", ddata, 8'h3C);
      data = 8'h11; idle(2);
      chk("R8 still holds", ddata, 8'h3C);

      idle(3);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule